// File: doc/BRIEF.md
# SPI Peripheral with Fault Detection

This block is a byte-wide serial peripheral interface controller that sits on a small register bus. Software configures it through a control register, watches a status register and moves bytes through a data register. As a master, it generates a divided serial clock and shifts one byte out and one byte in per data write. As a slave, it follows an external serial clock while its select input is held low.

Three error conditions are detected. A mode fault means another device pulled the select line low while this block was a master. A write collision means the data register was written during a transfer. A select error means the select line was released before a slave byte was complete. A mode fault takes the block out of service on its own. Each flag is cleared by its own register access sequence. One interrupt line reports a finished byte or a mode fault.

Register map (2-bit address): control at 0, status at 1, data at 2. Control fields: bit 7 enable, bit 6 master, bit 5 ignore-select, bits 1:0 clock divider. Status fields: bit 7 byte done, bit 6 write collision, bit 5 select error, bit 4 mode fault. Reads are combinational on `bus_rdata`. An access takes effect on the clock edge where `bus_sel` and `bus_wr` or `bus_rd` are high.

Top module: `spi_fault_ctrl`

## Requirements
- R1: After reset, control, status and data read as 0x00, `irq` is 0 and `sck_out` is 0.
- R2: With enable=1, master=1 and no transfer running, a data write starts an 8-bit transfer. The byte goes out on `mosi_out` MSB first and is valid at each rising `sck_out`. `miso_in` is sampled on each rising `sck_out`. At the end, status bit 7 sets and the received byte is read from data.
- R3: In master mode `sck_out` idles low and has a period of 2^(div+1) system clocks, where div is control bits 1:0.
- R4: With enable=1, master=1 and ignore-select=0, a low level on `ss_n_in` sets status bit 4 and clears control bits 7 and 6.
- R5: With ignore-select=1, a low `ss_n_in` never sets the mode fault flag.
- R6: Mode fault clears only on a control write that follows a status read which saw it set. Any control write made while the flag is still set leaves enable at 0.
- R7: A data write during a transfer sets status bit 6. The running transfer completes with its original byte, and the flag raises no interrupt.
- R8: Write collision clears on a data read or write that follows a status read which saw it set.
- R9: In slave mode, with `ss_n_in` low, the block samples `mosi_in` on rising `sck_in`. It presents its preloaded byte MSB first on `miso_out`, changing after falling `sck_in`. After 8 bits, status bit 7 sets and the byte is readable.
- R10: In slave mode, `ss_n_in` rising after 1 to 7 bits sets status bit 5 and raises no interrupt. A control write with bit 7 = 0 clears it. A release after a full byte sets nothing.
- R11: `irq` is high when byte done is set, or when mode fault is set and ignore-select is 0.
- R12: Byte done clears only on a data read or write that follows a status read which saw it set. A data read alone leaves it set.
- R13: If byte done is not cleared between two transfers, the data register holds the second received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (used for the clear sequences) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Interrupt request |
| sck_out | output | 1 | Serial clock in master mode |
| mosi_out | output | 1 | Serial data out in master mode |
| miso_in | input | 1 | Serial data in, master mode |
| sck_in | input | 1 | Serial clock in slave mode |
| mosi_in | input | 1 | Serial data in, slave mode |
| miso_out | output | 1 | Serial data out in slave mode |
| ss_n_in | input | 1 | Active-low select; fault sense in master mode |

## Verification
The hardest states to reach from the ports are the ones that need a bus access to arrive in the right phase of a serial transfer. A write collision needs a second data write while the shifter is mid-byte. A select error needs the select line to rise after only a few slave clocks. The bench handles both by choosing the slowest divider, so a master byte lasts 128 clocks and the second write lands well inside it. It drives the slave clock and select by hand with a fixed number of cycles per phase, which lets it stop after three bits. Mode fault and its clear sequence are driven through the same register accesses software would use. The out-of-order cases are included: a control write before the status read, and a data read without a status read.

// File: rtl/spi_fault_pkg.sv
package spi_fault_pkg;
  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_STAT = 2'd1;
  localparam logic [1:0] ADR_DATA = 2'd2;

  // system clocks per half period of the serial clock for a divider code
  function automatic int unsigned half_ticks(input int unsigned code);
    return 32'd1 << code;
  endfunction

  typedef struct packed {
    logic en;
    logic mst;
    logic ssoff;
  } ctrl_bits_t;
endpackage

// File: rtl/spi_fc_sckgen.sv
module spi_fc_sckgen
  import spi_fault_pkg::*;
#(
  parameter int DIV_W = 2,
  localparam int CW = 1 << DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sck,
  output logic             rise_ev,
  output logic             fall_ev
);
  logic [CW-1:0] cnt;
  logic          tick;

  assign tick    = run && (cnt == CW'(half_ticks(32'(div)) - 1));
  assign rise_ev = tick & ~sck;
  assign fall_ev = tick & sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  p_sck_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sck);
  p_sck_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !rise_ev && !fall_ev) |=> $stable(sck));
endmodule

// File: rtl/spi_fc_shifter.sv
module spi_fc_shifter #(
  parameter int DW = 8,
  parameter int DIV_W = 2,
  localparam int CNT_W = $clog2(DW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             mst,
  input  logic [DIV_W-1:0] div,
  input  logic             load,
  input  logic [DW-1:0]    load_data,
  input  logic             sck_in,
  input  logic             mosi_i,
  input  logic             miso_i,
  input  logic             ss_n_in,
  output logic             sck_out,
  output logic             mosi_o,
  output logic             miso_o,
  output logic             busy,
  output logic             xfer_done,
  output logic [DW-1:0]    rx_byte,
  output logic             ss_err_ev,
  output logic             ss_low
);
  logic [1:0]       ss_q;
  logic             ss_prev;
  logic [2:0]       sck_q;
  logic [1:0]       mosi_q;
  logic [DW-1:0]    sh;
  logic             out_bit;
  logic [CNT_W-1:0] cnt;
  logic             ss_s, ss_rise, s_rise, s_fall;
  logic             m_run, m_rise, m_fall;
  logic             m_last, s_last;

  // input synchronizers for the slave-side pins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_q    <= 2'b11;
      ss_prev <= 1'b1;
      sck_q   <= '0;
      mosi_q  <= '0;
    end else begin
      ss_q    <= {ss_q[0], ss_n_in};
      ss_prev <= ss_q[1];
      sck_q   <= {sck_q[1:0], sck_in};
      mosi_q  <= {mosi_q[0], mosi_i};
    end
  end

  assign ss_s    = ss_q[1];
  assign ss_low  = ~ss_s;
  assign ss_rise = ss_s & ~ss_prev;
  assign s_rise  = sck_q[1] & ~sck_q[2];
  assign s_fall  = ~sck_q[1] & sck_q[2];
  assign m_run   = busy & mst & en;

  spi_fc_sckgen #(.DIV_W(DIV_W)) u_sck (
    .clk(clk), .rst_n(rst_n), .run(m_run), .div(div),
    .sck(sck_out), .rise_ev(m_rise), .fall_ev(m_fall)
  );

  assign m_last    = m_fall && (cnt == CNT_W'(DW));
  assign s_last    = ~ss_s && s_rise && (cnt == CNT_W'(DW - 1));
  assign xfer_done = en && !load && (mst ? m_last : (s_last && !ss_rise));
  assign ss_err_ev = en && !mst && busy && ss_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      out_bit <= 1'b0;
      cnt     <= '0;
      busy    <= 1'b0;
      rx_byte <= '0;
    end else if (!en) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (load) begin
      sh      <= load_data;
      out_bit <= load_data[DW-1];
      cnt     <= '0;
      busy    <= mst;
    end else if (mst) begin
      if (m_rise) begin
        sh  <= {sh[DW-2:0], miso_i};
        cnt <= cnt + 1'b1;
      end
      if (m_fall) begin
        out_bit <= sh[DW-1];
        if (m_last) begin
          busy    <= 1'b0;
          cnt     <= '0;
          rx_byte <= sh;
        end
      end
    end else if (ss_rise) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!ss_s) begin
      if (s_rise) begin
        sh <= {sh[DW-2:0], mosi_q[1]};
        if (s_last) begin
          rx_byte <= {sh[DW-2:0], mosi_q[1]};
          cnt     <= '0;
          busy    <= 1'b0;
        end else begin
          cnt  <= cnt + 1'b1;
          busy <= 1'b1;
        end
      end
      if (s_fall) out_bit <= sh[DW-1];
    end
  end

  assign mosi_o = mst ? out_bit : 1'b0;
  assign miso_o = mst ? 1'b0 : out_bit;

  p_sserr_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ss_err_ev |=> !busy);
  p_master_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && mst) |=> (!busy && !sck_out));
endmodule

// File: rtl/spi_fc_regs.sv
module spi_fc_regs
  import spi_fault_pkg::*;
#(
  parameter int DW = 8,
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             wr,
  input  logic             rd,
  input  logic [1:0]       addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic             busy,
  input  logic             xfer_done,
  input  logic [DW-1:0]    rx_byte,
  input  logic             ss_err_ev,
  input  logic             ss_low,
  output logic             en,
  output logic             mst,
  output logic             ssoff,
  output logic [DIV_W-1:0] div,
  output logic             load,
  output logic [DW-1:0]    load_data,
  output logic             data_wr,
  output logic             modf_ev,
  output logic             irq
);
  ctrl_bits_t ctrl;
  logic ctrl_wr, stat_rd, data_rd, data_acc, wcol_ev;
  logic modf_r, modf_arm, done_r, done_arm, wcol_r, wcol_arm, sserr_r;

  assign ctrl_wr  = sel && wr && (addr == ADR_CTRL);
  assign stat_rd  = sel && rd && (addr == ADR_STAT);
  assign data_wr  = sel && wr && (addr == ADR_DATA);
  assign data_rd  = sel && rd && (addr == ADR_DATA);
  assign data_acc = data_wr || data_rd;

  assign en    = ctrl.en;
  assign mst   = ctrl.mst;
  assign ssoff = ctrl.ssoff;

  assign modf_ev   = ctrl.en && ctrl.mst && !ctrl.ssoff && ss_low;
  assign load      = data_wr && ctrl.en && !busy;
  assign load_data = wdata;
  assign wcol_ev   = data_wr && ctrl.en && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      div  <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl.en    <= wdata[DW-1] && !modf_r;
        ctrl.mst   <= wdata[DW-2];
        ctrl.ssoff <= wdata[DW-3];
        div        <= wdata[DIV_W-1:0];
      end
      if (modf_ev) begin
        ctrl.en  <= 1'b0;
        ctrl.mst <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modf_r <= 1'b0; modf_arm <= 1'b0;
      done_r <= 1'b0; done_arm <= 1'b0;
      wcol_r <= 1'b0; wcol_arm <= 1'b0;
      sserr_r <= 1'b0;
    end else begin
      if (modf_ev) modf_r <= 1'b1;
      else if (ctrl_wr && modf_arm) modf_r <= 1'b0;
      if (stat_rd && modf_r) modf_arm <= 1'b1;
      else if (ctrl_wr) modf_arm <= 1'b0;

      if (xfer_done) done_r <= 1'b1;
      else if (data_acc && done_arm) done_r <= 1'b0;
      if (stat_rd && done_r) done_arm <= 1'b1;
      else if (data_acc) done_arm <= 1'b0;

      if (wcol_ev) wcol_r <= 1'b1;
      else if (data_acc && wcol_arm) wcol_r <= 1'b0;
      if (stat_rd && wcol_r) wcol_arm <= 1'b1;
      else if (data_acc) wcol_arm <= 1'b0;

      if (ss_err_ev) sserr_r <= 1'b1;
      else if (ctrl_wr && !wdata[DW-1]) sserr_r <= 1'b0;
    end
  end

  assign irq = done_r || (modf_r && !ctrl.ssoff);

  always_comb begin
    rdata = '0;
    case (addr)
      ADR_CTRL: begin
        rdata[DW-1]      = ctrl.en;
        rdata[DW-2]      = ctrl.mst;
        rdata[DW-3]      = ctrl.ssoff;
        rdata[DIV_W-1:0] = div;
      end
      ADR_STAT: begin
        rdata[DW-1] = done_r;
        rdata[DW-2] = wcol_r;
        rdata[DW-3] = sserr_r;
        rdata[DW-4] = modf_r;
      end
      ADR_DATA: rdata = rx_byte;
      default:  rdata = '0;
    endcase
  end

  p_modf_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    modf_ev |=> (!ctrl.en && !ctrl.mst && modf_r));
  p_en_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && modf_r) |=> !ctrl.en);
  p_ssoff_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modf_r) |-> !$past(ctrl.ssoff));
  p_wcol_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wcol_ev |=> wcol_r);
  p_sserr_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wdata[DW-1] && !ss_err_ev) |=> !sserr_r);
  p_done_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (done_r && !done_arm) |=> done_r);
endmodule

// File: rtl/spi_fault_ctrl.sv
module spi_fault_ctrl #(
  parameter int DW = 8,
  parameter int DIV_W = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  output logic          sck_out,
  output logic          mosi_out,
  input  logic          miso_in,
  input  logic          sck_in,
  input  logic          mosi_in,
  output logic          miso_out,
  input  logic          ss_n_in
);
  logic             en, mst, ssoff, load, busy, xfer_done, ss_err_ev, ss_low;
  logic             data_wr, modf_ev;
  logic [DIV_W-1:0] div;
  logic [DW-1:0]    load_data, rx_byte;

  spi_fc_regs #(.DW(DW), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .rd(bus_rd),
    .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
    .busy(busy), .xfer_done(xfer_done), .rx_byte(rx_byte),
    .ss_err_ev(ss_err_ev), .ss_low(ss_low),
    .en(en), .mst(mst), .ssoff(ssoff), .div(div),
    .load(load), .load_data(load_data), .data_wr(data_wr),
    .modf_ev(modf_ev), .irq(irq)
  );

  spi_fc_shifter #(.DW(DW), .DIV_W(DIV_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .en(en), .mst(mst), .div(div),
    .load(load), .load_data(load_data),
    .sck_in(sck_in), .mosi_i(mosi_in), .miso_i(miso_in), .ss_n_in(ss_n_in),
    .sck_out(sck_out), .mosi_o(mosi_out), .miso_o(miso_out),
    .busy(busy), .xfer_done(xfer_done), .rx_byte(rx_byte),
    .ss_err_ev(ss_err_ev), .ss_low(ss_low)
  );

  // a colliding write must not disturb the byte in flight
  p_wcol_continue_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && busy && en && !xfer_done && !modf_ev && !ss_err_ev) |=> busy);
endmodule

// File: tb/sim_spi_fault_ctrl.sv
module sim_spi_fault_ctrl;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, bus_sel, bus_wr, bus_rd;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic irq, sck_out, mosi_out, miso_in, sck_in, mosi_in, miso_out, ss_n_in;

  assign miso_in = mosi_out;  // loopback for master transfers

  spi_fault_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .sck_out(sck_out),
    .mosi_out(mosi_out), .miso_in(miso_in), .sck_in(sck_in),
    .mosi_in(mosi_in), .miso_out(miso_out), .ss_n_in(ss_n_in)
  );

  int errs = 0;
  int checks = 0;
  int cyc = 0;
  int last_rise = 0;
  int period = 0;
  logic sck_d = 1'b0;
  logic [7:0] cap = '0;

  // observe the master clock away from the active edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (sck_out && !sck_d) begin
      cap = {cap[6:0], mosi_out};
      period = cyc - last_rise;
      last_rise = cyc;
    end
    sck_d = sck_out;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0; bus_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_irq(input string req);
    int k = 0;
    while (!irq && k < 3000) begin
      @(negedge clk);
      k++;
    end
    chk(req, irq, 1'b1);
  endtask

  task automatic slave_bit(input logic b, output logic seen);
    mosi_in = b;
    idle(6);
    seen = miso_out;
    sck_in = 1;
    idle(6);
    sck_in = 0;
    idle(6);
  endtask

  // {divider, byte to send}
  localparam logic [9:0] VEC [6] = '{
    {2'd0, 8'hA5}, {2'd1, 8'h3C}, {2'd2, 8'h81},
    {2'd3, 8'h7E}, {2'd0, 8'h00}, {2'd1, 8'hFF}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic       s;
    logic [7:0] mcap;
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    sck_in = 0; mosi_in = 0; ss_n_in = 1;
    idle(3);
    rst_n = 1;
    idle(2);

    // R1 reset state
    rd_reg(2'd0, r); chk("R1 ctrl", r, 8'h00);
    rd_reg(2'd1, r); chk("R1 status", r, 8'h00);
    rd_reg(2'd2, r); chk("R1 data", r, 8'h00);
    chk("R1 irq", irq, 1'b0);
    chk("R1 sck", sck_out, 1'b0);

    // R2/R3 vector walk over dividers and patterns
    for (int i = 0; i < 6; i++) begin
      wr_reg(2'd0, 8'hC0 | {6'd0, VEC[i][9:8]});
      wr_reg(2'd2, VEC[i][7:0]);
      wait_irq("R2 done irq");
      idle(1);
      chk("R2 mosi msb first", cap, VEC[i][7:0]);
      chk("R3 sck period", period, 32'd2 << VEC[i][9:8]);
      chk("R3 sck idle low", sck_out, 1'b0);
      rd_reg(2'd1, r); chk("R2 status done", r, 8'h80);
      rd_reg(2'd2, r); chk("R2 rx byte", r, VEC[i][7:0]);
      chk("R12 irq cleared", irq, 1'b0);
    end

    // R12 data read alone does not clear done
    wr_reg(2'd2, 8'h96);
    wait_irq("R12 done");
    rd_reg(2'd2, r); chk("R12 data only", irq, 1'b1);
    rd_reg(2'd1, r);
    rd_reg(2'd2, r); chk("R12 seq clears", irq, 1'b0);

    // R13 overrun keeps latest byte
    wr_reg(2'd0, 8'hC0);
    wr_reg(2'd2, 8'h11);
    wait_irq("R13 first");
    wr_reg(2'd2, 8'h22);
    idle(40);
    rd_reg(2'd1, r);
    rd_reg(2'd2, r); chk("R13 latest byte", r, 8'h22);

    // R7/R8 write collision on slowest divider
    wr_reg(2'd0, 8'hC3);
    wr_reg(2'd2, 8'h5A);
    idle(10);
    wr_reg(2'd2, 8'hFF);
    rd_reg(2'd1, r); chk("R7 wcol set", r, 8'h40);
    chk("R7 no irq", irq, 1'b0);
    wait_irq("R7 transfer finishes");
    idle(1);
    chk("R7 original byte sent", cap, 8'h5A);
    rd_reg(2'd2, r); chk("R7 original byte rx", r, 8'h5A);
    rd_reg(2'd1, r); chk("R8 wcol cleared", r, 8'h80);
    rd_reg(2'd2, r); chk("R12 done cleared", irq, 1'b0);

    // R9 slave byte with preloaded reply
    wr_reg(2'd0, 8'h80);
    wr_reg(2'd2, 8'hC3);
    ss_n_in = 0; idle(4);
    mcap = '0;
    for (int b = 7; b >= 0; b--) begin
      slave_bit(((8'h6D >> b) & 8'h01) != 0, s);
      mcap = {mcap[6:0], s};
    end
    ss_n_in = 1; idle(6);
    chk("R9 miso bits", mcap, 8'hC3);
    chk("R9 irq", irq, 1'b1);
    rd_reg(2'd1, r); chk("R10 full byte no sserr", r, 8'h80);
    rd_reg(2'd2, r); chk("R9 rx byte", r, 8'h6D);

    // R10 early select release
    ss_n_in = 0; idle(4);
    for (int b = 0; b < 3; b++) slave_bit(1'b1, s);
    ss_n_in = 1; idle(6);
    chk("R10 no irq", irq, 1'b0);
    rd_reg(2'd1, r); chk("R10 sserr set", r, 8'h20);
    wr_reg(2'd0, 8'h00);
    rd_reg(2'd1, r); chk("R10 sserr cleared", r, 8'h00);

    // R5 ignore-select blocks fault
    wr_reg(2'd0, 8'hE0);
    ss_n_in = 0; idle(5);
    rd_reg(2'd0, r); chk("R5 ctrl kept", r, 8'hE0);
    rd_reg(2'd1, r); chk("R5 no modf", r, 8'h00);
    ss_n_in = 1; idle(3);

    // R4/R6/R11 mode fault
    wr_reg(2'd0, 8'hC2);
    ss_n_in = 0; idle(5);
    rd_reg(2'd0, r); chk("R4 en and mst cleared", r, 8'h02);
    chk("R11 irq from modf", irq, 1'b1);
    ss_n_in = 1; idle(3);
    wr_reg(2'd0, 8'h20);
    chk("R11 ssoff masks modf", irq, 1'b0);
    rd_reg(2'd1, r); chk("R6 modf kept without read", r, 8'h10);
    wr_reg(2'd0, 8'hC0);
    rd_reg(2'd0, r); chk("R6 en blocked", r, 8'h40);
    rd_reg(2'd1, r); chk("R6 modf cleared", r, 8'h00);
    wr_reg(2'd0, 8'hC0);
    rd_reg(2'd0, r); chk("R6 en restored", r, 8'hC0);
    chk("R11 irq low", irq, 1'b0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule